// File: doc/BRIEF.md
# Coprocessor Exception Handshake Controller

This block lives on the coprocessor side of a register-mapped host interface. It reports exception conditions to the host and runs the handshake that follows. The datapath can raise an arithmetic condition (five flag kinds), a branch-on-unordered condition or an unimplemented-opcode condition. The block also raises a protocol violation itself when the host touches an interface register in a way the current state does not allow. For each of these it loads a take-exception primitive and an 8-bit vector number into a 16-bit response word.

The host finds the report when it reads the response register, usually as it tries to start its next instruction. It then acknowledges by writing a fixed acknowledge code to the control register. The block runs a one-cycle clean-up for that class: it aborts all activity after a protocol violation, and clears the pending exception for every other class. It then returns to idle with a null response. The host forms its dispatch-table offset as the vector number times four, so 256 vectors index a 1024-byte table. Only one exception is ever pending.

Top module: `cpx_exc_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the block returns to idle: resp_word becomes 16'h0000 and abort_all and clear_exc become 0.
- R2: resp_word is laid out as follows. Bits [15:13] hold the primitive: 000 null, 001 pre-instruction exception, 010 mid-instruction exception. Bits [12:8] are zero and bits [7:0] hold the vector number.
- R3: An arithmetic condition raised while no instruction is in progress (idle) reports the pre-instruction primitive. One raised while an instruction is in progress (busy) reports the mid-instruction primitive. Branch-unordered and unimplemented-opcode conditions always report the pre-instruction primitive.
- R4: Simultaneous causes are resolved in this order: protocol violation, then arithmetic, then branch-unordered (vector 48), then unimplemented opcode (vector 11). Within arith_flags the order is bit4 operand error (52), bit3 overflow (53), bit2 underflow (51), bit1 divide by zero (50), bit0 inexact (49).
- R5: A loaded primitive stays in resp_word, unchanged, until the acknowledge clean-up. Datapath causes that arrive while an exception is pending, read or in clean-up are dropped.
- R6: Only a control-register write of 16'h0001 that comes after the host has read the response starts the clean-up. The pulse lasts exactly one cycle, and on the following edge resp_word returns to null.
- R7: Register select acc_sel uses 0 response, 1 control, 2 command, 3 operand. An access is illegal in any of these cases: a write to response; a read of control or command; a control write in any state other than after-read, or with a value other than 16'h0001; a command write in any state other than idle; an operand access in any state other than busy. Response reads are always legal.
- R8: An illegal access loads the mid-instruction primitive with vector 13 on the next edge. This overrides any exception already pending.
- R9: Acknowledging a protocol violation pulses abort_all. Acknowledging any other class pulses clear_exc. The two are never high together.
- R10: A legal command write in idle starts an instruction (busy). op_done in busy returns to idle. op_done has no effect in other states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Host register access this cycle |
| acc_write | input | 1 | 1 write, 0 read |
| acc_sel | input | 2 | Register select: 0 response, 1 control, 2 command, 3 operand |
| acc_wdata | input | 16 | Host write data |
| arith_flags | input | 5 | Arithmetic conditions from the datapath |
| unord_exc | input | 1 | Branch-on-unordered condition |
| unimp_exc | input | 1 | Unimplemented-opcode condition |
| op_done | input | 1 | Datapath finished the current instruction |
| resp_word | output | 16 | Response register contents |
| abort_all | output | 1 | One-cycle abort of all internal operations |
| clear_exc | output | 1 | One-cycle clear of the pending exception |

## Verification
Every output is registered. A cause, an access or an acknowledge presented in one cycle therefore shows on resp_word, abort_all or clear_exc after exactly one clock edge. The clean-up pulse is high for that single cycle, and the null response follows one edge later. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares at the next falling edge against a reference model stepped at that same rising edge, so each expected value lines up with the cycle in which it is due. Directed sequences cover the priority order, the idle and busy primitive choice, override by a violation and every illegal access kind. A seeded random run then covers the remaining interleavings.

// File: rtl/cpx_exc_pkg.sv
// Shared types and encodings for the coprocessor exception handshake controller.
// Assumes a 2-bit register select and a 3-bit primitive field at the top of the response word.
package cpx_exc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BUSY,
        ST_EXC_PENDING,
        ST_EXC_READ,
        ST_CLEANUP
    } cpx_state_e;

    typedef enum logic [1:0] {
        CLS_PROTO,
        CLS_ARITH,
        CLS_UNORD,
        CLS_UNIMP
    } cpx_class_e;

    localparam logic [2:0] PRIM_NULL = 3'b000;
    localparam logic [2:0] PRIM_PRE  = 3'b001;
    localparam logic [2:0] PRIM_MID  = 3'b010;

    localparam logic [1:0] SEL_RESP = 2'd0;
    localparam logic [1:0] SEL_CTRL = 2'd1;
    localparam logic [1:0] SEL_CMD  = 2'd2;
    localparam logic [1:0] SEL_OPND = 2'd3;

endpackage

// File: rtl/cpx_access_check.sv
// Classifies one host register access against the current handshake state.
// Flags illegal accesses (protocol violations) and decodes the legal events the FSM uses.
// Assumes at most one access per cycle; output is purely combinational.
module cpx_access_check
    import cpx_exc_pkg::*;
#(
    parameter int          DATA_W   = 16,
    parameter logic [15:0] ACK_CODE = 16'h0001
) (
    input  cpx_state_e        state,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic              illegal,
    output logic              resp_read,
    output logic              ack_write,
    output logic              cmd_write
);

    logic ack_value;
    assign ack_value = (acc_wdata == DATA_W'(ACK_CODE));

    // Decide legality of the access from the register, direction and state.
    always_comb begin
        illegal   = 1'b0;
        resp_read = 1'b0;
        ack_write = 1'b0;
        cmd_write = 1'b0;
        if (acc_valid) begin
            unique case (acc_sel)
                SEL_RESP: begin
                    if (acc_write) illegal   = 1'b1;
                    else           resp_read = 1'b1;
                end
                SEL_CTRL: begin
                    if (acc_write && ack_value && state == ST_EXC_READ) ack_write = 1'b1;
                    else                                                illegal   = 1'b1;
                end
                SEL_CMD: begin
                    if (acc_write && state == ST_IDLE) cmd_write = 1'b1;
                    else                               illegal   = 1'b1;
                end
                default: begin
                    if (state != ST_BUSY) illegal = 1'b1;
                end
            endcase
        end
    end

endmodule

// File: rtl/cpx_cause_select.sv
// Picks the single datapath cause to report when several arrive together.
// Order: arithmetic (highest flag index first), then branch-unordered, then unimplemented opcode.
// Protocol violations are ranked above all of these by the FSM, not here.
module cpx_cause_select
    import cpx_exc_pkg::*;
#(
    parameter int                         VEC_W      = 8,
    parameter int                         ARITH_N    = 5,
    parameter logic [ARITH_N*VEC_W-1:0]   ARITH_VECS = {8'd52, 8'd53, 8'd51, 8'd50, 8'd49},
    parameter logic [VEC_W-1:0]           VEC_UNORD  = 8'd48,
    parameter logic [VEC_W-1:0]           VEC_UNIMP  = 8'd11
) (
    input  logic [ARITH_N-1:0] arith_flags,
    input  logic               unord_exc,
    input  logic               unimp_exc,
    output logic               cause_valid,
    output cpx_class_e         cause_class,
    output logic [VEC_W-1:0]   cause_vec
);

    // Lowest-ranked cause first so that higher-ranked ones overwrite it.
    always_comb begin
        cause_valid = 1'b0;
        cause_class = CLS_UNIMP;
        cause_vec   = '0;
        if (unimp_exc) begin
            cause_valid = 1'b1;
            cause_class = CLS_UNIMP;
            cause_vec   = VEC_UNIMP;
        end
        if (unord_exc) begin
            cause_valid = 1'b1;
            cause_class = CLS_UNORD;
            cause_vec   = VEC_UNORD;
        end
        for (int i = 0; i < ARITH_N; i++) begin
            if (arith_flags[i]) begin
                cause_valid = 1'b1;
                cause_class = CLS_ARITH;
                cause_vec   = ARITH_VECS[i*VEC_W +: VEC_W];
            end
        end
    end

endmodule

// File: rtl/cpx_exc_fsm.sv
// Handshake state machine: loads the response word, waits for read and acknowledge,
// issues the per-class clean-up pulse and returns to idle.
// Assumes decoded access events and a single selected cause as inputs.
module cpx_exc_fsm
    import cpx_exc_pkg::*;
#(
    parameter int               RESP_W    = 16,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_PROTO = 8'd13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              illegal,
    input  logic              resp_read,
    input  logic              ack_write,
    input  logic              cmd_write,
    input  logic              op_done,
    input  logic              cause_valid,
    input  cpx_class_e        cause_class,
    input  logic [VEC_W-1:0]  cause_vec,
    output cpx_state_e        state,
    output logic [RESP_W-1:0] resp_word,
    output logic              abort_all,
    output logic              clear_exc
);

    localparam int PRIM_W = 3;

    cpx_state_e        state_q, state_d;
    cpx_class_e        cls_q, cls_d;
    logic [RESP_W-1:0] resp_q, resp_d;
    logic              abort_q, abort_d;
    logic              clear_q, clear_d;

    function automatic logic [RESP_W-1:0] pack_resp(input logic [PRIM_W-1:0] prim,
                                                    input logic [VEC_W-1:0]  vec);
        logic [RESP_W-1:0] w;
        w = '0;
        w[RESP_W-1 -: PRIM_W] = prim;
        w[VEC_W-1:0]          = vec;
        return w;
    endfunction

    // Next-state, next-response and clean-up pulse decision.
    always_comb begin
        state_d = state_q;
        cls_d   = cls_q;
        resp_d  = resp_q;
        abort_d = 1'b0;
        clear_d = 1'b0;
        if (illegal) begin
            state_d = ST_EXC_PENDING;
            cls_d   = CLS_PROTO;
            resp_d  = pack_resp(PRIM_MID, VEC_PROTO);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cause_valid) begin
                        state_d = ST_EXC_PENDING;
                        cls_d   = cause_class;
                        resp_d  = pack_resp(PRIM_PRE, cause_vec);
                    end else if (cmd_write) begin
                        state_d = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (cause_valid) begin
                        state_d = ST_EXC_PENDING;
                        cls_d   = cause_class;
                        resp_d  = pack_resp((cause_class == CLS_ARITH) ? PRIM_MID : PRIM_PRE,
                                            cause_vec);
                    end else if (op_done) begin
                        state_d = ST_IDLE;
                    end
                end
                ST_EXC_PENDING: begin
                    if (resp_read) state_d = ST_EXC_READ;
                end
                ST_EXC_READ: begin
                    if (ack_write) begin
                        state_d = ST_CLEANUP;
                        abort_d = (cls_q == CLS_PROTO);
                        clear_d = (cls_q != CLS_PROTO);
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    resp_d  = pack_resp(PRIM_NULL, '0);
                end
            endcase
        end
    end

    // State and output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cls_q   <= CLS_PROTO;
            resp_q  <= '0;
            abort_q <= 1'b0;
            clear_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cls_q   <= cls_d;
            resp_q  <= resp_d;
            abort_q <= abort_d;
            clear_q <= clear_d;
        end
    end

    assign state     = state_q;
    assign resp_word = resp_q;
    assign abort_all = abort_q;
    assign clear_exc = clear_q;

endmodule

// File: rtl/cpx_exc_ctrl.sv
// Top of the coprocessor exception handshake controller.
// Wires access legality, cause priority and the handshake FSM together.
// Assumes host accesses and datapath causes are synchronous to clk.
module cpx_exc_ctrl
    import cpx_exc_pkg::*;
#(
    parameter int                       RESP_W     = 16,
    parameter int                       VEC_W      = 8,
    parameter int                       ARITH_N    = 5,
    parameter logic [ARITH_N*VEC_W-1:0] ARITH_VECS = {8'd52, 8'd53, 8'd51, 8'd50, 8'd49},
    parameter logic [VEC_W-1:0]         VEC_UNORD  = 8'd48,
    parameter logic [VEC_W-1:0]         VEC_UNIMP  = 8'd11,
    parameter logic [VEC_W-1:0]         VEC_PROTO  = 8'd13,
    parameter logic [15:0]              ACK_CODE   = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_sel,
    input  logic [RESP_W-1:0] acc_wdata,
    input  logic [ARITH_N-1:0] arith_flags,
    input  logic              unord_exc,
    input  logic              unimp_exc,
    input  logic              op_done,
    output logic [RESP_W-1:0] resp_word,
    output logic              abort_all,
    output logic              clear_exc
);

    cpx_state_e       state;
    logic             illegal, resp_read, ack_write, cmd_write;
    logic             cause_valid;
    cpx_class_e       cause_class;
    logic [VEC_W-1:0] cause_vec;

    cpx_access_check #(
        .DATA_W  (RESP_W),
        .ACK_CODE(ACK_CODE)
    ) acc_i (
        .state    (state),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_sel  (acc_sel),
        .acc_wdata(acc_wdata),
        .illegal  (illegal),
        .resp_read(resp_read),
        .ack_write(ack_write),
        .cmd_write(cmd_write)
    );

    cpx_cause_select #(
        .VEC_W     (VEC_W),
        .ARITH_N   (ARITH_N),
        .ARITH_VECS(ARITH_VECS),
        .VEC_UNORD (VEC_UNORD),
        .VEC_UNIMP (VEC_UNIMP)
    ) sel_i (
        .arith_flags(arith_flags),
        .unord_exc  (unord_exc),
        .unimp_exc  (unimp_exc),
        .cause_valid(cause_valid),
        .cause_class(cause_class),
        .cause_vec  (cause_vec)
    );

    cpx_exc_fsm #(
        .RESP_W   (RESP_W),
        .VEC_W    (VEC_W),
        .VEC_PROTO(VEC_PROTO)
    ) fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .illegal    (illegal),
        .resp_read  (resp_read),
        .ack_write  (ack_write),
        .cmd_write  (cmd_write),
        .op_done    (op_done),
        .cause_valid(cause_valid),
        .cause_class(cause_class),
        .cause_vec  (cause_vec),
        .state      (state),
        .resp_word  (resp_word),
        .abort_all  (abort_all),
        .clear_exc  (clear_exc)
    );

endmodule

// File: rtl/cpx_exc_checker.sv
// Property checker for cpx_exc_ctrl, attached through bind.
// Observes ports only; assumes the default register select encoding.
module cpx_exc_checker #(
    parameter int               RESP_W    = 16,
    parameter int               VEC_W     = 8,
    parameter logic [VEC_W-1:0] VEC_PROTO = 8'd13,
    parameter logic [15:0]      ACK_CODE  = 16'h0001
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [1:0]        acc_sel,
    input logic [RESP_W-1:0] acc_wdata,
    input logic [RESP_W-1:0] resp_word,
    input logic              abort_all,
    input logic              clear_exc
);

    localparam logic [RESP_W-1:0] PROTO_WORD =
        {3'b010, {(RESP_W-3-VEC_W){1'b0}}, VEC_PROTO};

    // R1: reset returns a null response and no pulses
    a_r1_reset_null: assert property (@(posedge clk)
        !rst_n |=> (resp_word == '0 && !abort_all && !clear_exc));

    // R2: only the three primitive codes, gap bits zero
    a_r2_resp_layout: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_word[RESP_W-1 -: 3] inside {3'b000, 3'b001, 3'b010})
        && resp_word[RESP_W-4:VEC_W] == '0);

    // R9: clean-up pulses never overlap
    a_r9_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({abort_all, clear_exc}));

    // R6: a clean-up pulse lasts one cycle
    a_r6_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_all || clear_exc) |=> !(abort_all || clear_exc));

    // R6: a pulse follows an acknowledge write
    a_r6_ack_before_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(abort_all) || $rose(clear_exc)) |->
        $past(acc_valid && acc_write && acc_sel == 2'd1 && acc_wdata == RESP_W'(ACK_CODE)));

    // R8: a write to the response register is reported as a violation
    a_r8_resp_write_violation: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && acc_sel == 2'd0) |=> resp_word == PROTO_WORD);

    // R5: a loaded primitive holds while the host is silent
    a_r5_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_word != '0 && !acc_valid && !abort_all && !clear_exc) |=> $stable(resp_word));

endmodule

bind cpx_exc_ctrl cpx_exc_checker #(
    .RESP_W   (RESP_W),
    .VEC_W    (VEC_W),
    .VEC_PROTO(VEC_PROTO),
    .ACK_CODE (ACK_CODE)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_sel  (acc_sel),
    .acc_wdata(acc_wdata),
    .resp_word(resp_word),
    .abort_all(abort_all),
    .clear_exc(clear_exc)
);

// File: tb/cpx_exc_ctrl_tb_top.sv
`timescale 1ns/1ps
// Bench for cpx_exc_ctrl: directed handshakes, then seeded random traffic against a reference model.
module cpx_exc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_sel = 2'd0;
    logic [15:0] acc_wdata = 16'h0;
    logic [4:0]  arith_flags = 5'h0;
    logic        unord_exc = 1'b0, unimp_exc = 1'b0, op_done = 1'b0;
    logic [15:0] resp_word;
    logic        abort_all, clear_exc;

    int checks = 0;
    int errors = 0;

    // model: 0 idle, 1 busy, 2 pending, 3 read, 4 cleanup; cls 0 = violation
    int          m_state = 0;
    int          m_cls = 0;
    logic [15:0] m_resp = 16'h0;
    logic        m_abort = 1'b0, m_clear = 1'b0;

    cpx_exc_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_sel(acc_sel), .acc_wdata(acc_wdata), .arith_flags(arith_flags),
        .unord_exc(unord_exc), .unimp_exc(unimp_exc), .op_done(op_done),
        .resp_word(resp_word), .abort_all(abort_all), .clear_exc(clear_exc)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic is_illegal(input int st);
        if (!acc_valid) return 1'b0;
        case (acc_sel)
            2'd0:    return acc_write;
            2'd1:    return !(acc_write && acc_wdata == 16'h0001 && st == 3);
            2'd2:    return !(acc_write && st == 0);
            default: return st != 1;
        endcase
    endfunction

    task automatic model_step();
        logic       ill, cv, ar;
        logic [7:0] vec;
        int         cls;
        m_abort = 1'b0;
        m_clear = 1'b0;
        if (!rst_n) begin
            m_state = 0; m_cls = 0; m_resp = 16'h0;
            return;
        end
        ill = is_illegal(m_state);
        cv = 1'b1; ar = 1'b0; cls = 1; vec = 8'd0;
        if      (arith_flags[4]) begin vec = 8'd52; ar = 1'b1; end
        else if (arith_flags[3]) begin vec = 8'd53; ar = 1'b1; end
        else if (arith_flags[2]) begin vec = 8'd51; ar = 1'b1; end
        else if (arith_flags[1]) begin vec = 8'd50; ar = 1'b1; end
        else if (arith_flags[0]) begin vec = 8'd49; ar = 1'b1; end
        else if (unord_exc)      vec = 8'd48;
        else if (unimp_exc)      vec = 8'd11;
        else                     cv = 1'b0;
        if (ill) begin
            m_state = 2; m_cls = 0; m_resp = 16'h400D;
        end else begin
            case (m_state)
                0: if (cv) begin m_state = 2; m_cls = cls; m_resp = {8'h20, vec}; end
                   else if (acc_valid && acc_write && acc_sel == 2'd2) m_state = 1;
                1: if (cv) begin m_state = 2; m_cls = cls; m_resp = {ar ? 8'h40 : 8'h20, vec}; end
                   else if (op_done) m_state = 0;
                2: if (acc_valid && !acc_write && acc_sel == 2'd0) m_state = 3;
                3: if (acc_valid && acc_write && acc_sel == 2'd1) begin
                       m_state = 4; m_abort = (m_cls == 0); m_clear = (m_cls != 0);
                   end
                default: begin m_state = 0; m_resp = 16'h0; end
            endcase
        end
    endtask

    // One clock: inputs already set; step model at the edge, compare at the falling edge.
    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R2 model resp", resp_word, m_resp);
        chk("R9 model pulses", {14'h0, abort_all, clear_exc}, {14'h0, m_abort, m_clear});
        acc_valid = 1'b0; acc_write = 1'b0; acc_sel = 2'd0; acc_wdata = 16'h0;
        arith_flags = 5'h0; unord_exc = 1'b0; unimp_exc = 1'b0; op_done = 1'b0;
    endtask

    task automatic access(input logic wr, input logic [1:0] sel, input logic [15:0] d);
        acc_valid = 1'b1; acc_write = wr; acc_sel = sel; acc_wdata = d;
        tick();
    endtask

    // Read the response, acknowledge, and let the clean-up cycle finish.
    task automatic finish_exc(input logic expect_abort);
        access(1'b0, 2'd0, 16'h0);
        access(1'b1, 2'd1, 16'h0001);
        chk("R9 abort on ack", {15'h0, abort_all}, {15'h0, expect_abort});
        chk("R9 clear on ack", {15'h0, clear_exc}, {15'h0, !expect_abort});
        tick();
        chk("R6 null after cleanup", resp_word, 16'h0000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd24681));
        @(negedge clk);
        rst_n = 1'b0;
        tick(); tick();
        chk("R1 reset resp", resp_word, 16'h0000);
        chk("R1 reset pulses", {14'h0, abort_all, clear_exc}, 16'h0);
        rst_n = 1'b1;
        tick();

        // R3 idle arithmetic -> pre primitive; R2 layout
        arith_flags = 5'b00100; tick();
        chk("R3 idle underflow pre", resp_word, 16'h2033);
        tick(); tick();
        unord_exc = 1'b1; arith_flags = 5'b10000; tick();
        chk("R5 held and later cause dropped", resp_word, 16'h2033);
        finish_exc(1'b0);

        // R10 start instruction; R3 busy arithmetic -> mid; R4 arith order
        access(1'b1, 2'd2, 16'h0);
        access(1'b0, 2'd3, 16'h0);
        chk("R7 operand legal while busy", resp_word, 16'h0000);
        arith_flags = 5'b10001; tick();
        chk("R3 R4 busy operr mid", resp_word, 16'h4034);
        finish_exc(1'b0);

        // R4 priority among datapath causes
        arith_flags = 5'b00010; unord_exc = 1'b1; unimp_exc = 1'b1; tick();
        chk("R4 dz over unord", resp_word, 16'h2032);
        finish_exc(1'b0);
        unord_exc = 1'b1; unimp_exc = 1'b1; tick();
        chk("R4 unord over unimp", resp_word, 16'h2030);
        finish_exc(1'b0);
        access(1'b1, 2'd2, 16'h0);
        unimp_exc = 1'b1; tick();
        chk("R3 unimp pre while busy", resp_word, 16'h200B);
        finish_exc(1'b0);

        // R8 violation on response write, R9 abort
        access(1'b1, 2'd0, 16'h1234);
        chk("R8 response write violation", resp_word, 16'h400D);
        finish_exc(1'b1);

        // R8 override; R6 ack before read is illegal
        arith_flags = 5'b00001; tick();
        chk("R3 inexact pre", resp_word, 16'h2031);
        access(1'b1, 2'd1, 16'h0001);
        chk("R6 R8 early ack overrides", resp_word, 16'h400D);
        finish_exc(1'b1);

        // R10 op_done ends instruction; command while busy illegal
        access(1'b1, 2'd2, 16'h0);
        op_done = 1'b1; tick();
        access(1'b1, 2'd2, 16'h0);
        chk("R10 command legal after op_done", resp_word, 16'h0000);
        access(1'b1, 2'd2, 16'h0);
        chk("R7 command while busy", resp_word, 16'h400D);
        finish_exc(1'b1);
        op_done = 1'b1; tick();
        access(1'b0, 2'd3, 16'h0);
        chk("R10 R7 op_done idle ignored, operand illegal", resp_word, 16'h400D);
        finish_exc(1'b1);

        // R6 non-ack control value after read
        arith_flags = 5'b01000; tick();
        chk("R4 overflow vector", resp_word, 16'h2035);
        access(1'b0, 2'd0, 16'h0);
        access(1'b1, 2'd1, 16'h0002);
        chk("R6 wrong ack value", resp_word, 16'h400D);
        chk("R6 no pulse on wrong value", {14'h0, abort_all, clear_exc}, 16'h0);
        finish_exc(1'b1);
        access(1'b0, 2'd1, 16'h0);
        chk("R7 control read illegal", resp_word, 16'h400D);
        finish_exc(1'b1);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 35) begin
                acc_valid = 1'b1;
                acc_sel = 2'($urandom_range(0, 3));
                acc_write = ($urandom_range(0, 3) != 0);
                if (acc_sel == 2'd0 && $urandom_range(0, 3) != 0) acc_write = 1'b0;
                acc_wdata = ($urandom_range(0, 9) < 8) ? 16'h0001 : 16'($urandom);
            end
            if ($urandom_range(0, 9) == 0) arith_flags = 5'($urandom);
            unord_exc = ($urandom_range(0, 19) == 0);
            unimp_exc = ($urandom_range(0, 19) == 0);
            op_done = ($urandom_range(0, 4) == 0);
            if ($urandom_range(0, 499) == 0) rst_n = 1'b0;
            tick();
            rst_n = 1'b1;
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule